// File: doc/BRIEF.md
# I2C interrupt and flag controller

This block holds the status flags of an I2C master and turns them into two interrupt lines: one for bus events and one for bus errors. The byte engine sends a one-cycle set pulse for each flag when the condition occurs. Software reads and clears the flags through a small register port. The byte engine also signals each access to the data register, and some flags clear on those accesses.

Three enable bits in the second control register gate the interrupts. Each flag clears in one of three ways. The error flags clear when software writes zero to their bit. Some event flags clear on a read sequence. The buffer flags clear on a single data-register access. Both interrupt outputs are plain levels, computed from the registered flags and enables.

Top module: `i2cirq_top`

## Requirements
- R1: After reset, every status flag, the control register and both interrupt outputs are 0.
- R2: The control register sits at offset 0x04. Bits 5:0 hold the input clock frequency in MHz. Bit 8 enables the error interrupt, bit 9 enables the event interrupt and bit 10 enables the buffer interrupt. All other bits read 0. The second status register (offset 0x18) reads 0, and any unmapped offset reads 0.
- R3: A set pulse makes its flag visible one cycle later in status register 1 (offset 0x14), also mirrored on `statusOut`, at these bits: start sent 0, address done 1, byte finished 2, receive full 6, transmit empty 7, bus error 8, arbitration lost 9, acknowledge failure 10. The set-pulse index order is start, address, byte finished, receive full, transmit empty, bus error, arbitration lost, acknowledge failure (index 0 to 7).
- R4: `evtIrq` is high while the event enable is set and any of start, address or byte-finished is set.
- R5: Transmit empty and receive full raise `evtIrq` only when the event enable and the buffer enable are both set.
- R6: `errIrq` is high while the error enable is set and any of the three error flags is set.
- R7: Writing status register 1 clears an error flag whose bit is written 0 and keeps one whose bit is written 1. The write has no effect on the other flags.
- R8: The start flag clears on a data-register write only after status register 1 has been read while the flag was set. A data-register write without that read leaves it set.
- R9: The address flag clears on a read of status register 2 only after status register 1 has been read while the flag was set. A read of status register 2 alone leaves it set.
- R10: The byte-finished flag clears on a data-register read or write after status register 1 has been read while the flag was set.
- R11: A data-register write clears transmit empty. A data-register read clears receive full.
- R12: A set pulse wins over a clear in the same cycle. For a flag that clears on a read sequence, that cycle also cancels the earlier status read, so clearing needs a fresh read of status register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (read side effects take place at the clock edge) |
| regWrData | input | REG_W | Register write data |
| regRdData | output | REG_W | Read data for the addressed register, valid in the strobe cycle |
| dataWrStb | input | 1 | Data-register write seen by the byte engine |
| dataRdStb | input | 1 | Data-register read seen by the byte engine |
| setPulse | input | 8 | One set pulse per flag, in the index order of R3 |
| statusOut | output | REG_W | Live copy of status register 1 |
| evtIrq | output | 1 | Event interrupt level |
| errIrq | output | 1 | Error interrupt level |

## Verification
A set pulse for a flag can arrive in the same cycle as the access that would clear it. The bench provokes this three ways: a transmit-empty pulse during a data-register write, an acknowledge-failure pulse during a zero write to status register 1, and a start pulse during the data-register write that follows a status read. In each case it judges that the flag stays set. For the start flag it also checks that a second write alone does not clear it, and that it clears only after another status read.

// File: rtl/i2cirq_pkg.sv
package i2cirq_pkg;

  localparam int NUM_FLAGS = 8;

  // flag indices (order of the setPulse vector)
  localparam int FL_SB   = 0;
  localparam int FL_ADDR = 1;
  localparam int FL_BTF  = 2;
  localparam int FL_RXNE = 3;
  localparam int FL_TXE  = 4;
  localparam int FL_BERR = 5;
  localparam int FL_ARLO = 6;
  localparam int FL_AF   = 7;

  // bit positions inside status register 1 (software decodes these)
  localparam int POS_SB   = 0;
  localparam int POS_ADDR = 1;
  localparam int POS_BTF  = 2;
  localparam int POS_RXNE = 6;
  localparam int POS_TXE  = 7;
  localparam int POS_BERR = 8;
  localparam int POS_ARLO = 9;
  localparam int POS_AF   = 10;

  // control register 2 fields
  localparam int FREQ_W     = 6;
  localparam int ERREN_BIT  = 8;
  localparam int EVTEN_BIT  = 9;
  localparam int BUFEN_BIT  = 10;

  // register offsets
  localparam int OFS_CR2 = 'h04;
  localparam int OFS_SR1 = 'h14;
  localparam int OFS_SR2 = 'h18;

  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_CR2  = 2'd1,
    RS_SR1  = 2'd2,
    RS_SR2  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic cr2Wr;
    logic sr1Wr;
    logic sr1Rd;
    logic sr2Rd;
    logic dataWr;
    logic dataRd;
  } strobe_t;

  function automatic int statusPos(input int idx);
    case (idx)
      FL_SB:   return POS_SB;
      FL_ADDR: return POS_ADDR;
      FL_BTF:  return POS_BTF;
      FL_RXNE: return POS_RXNE;
      FL_TXE:  return POS_TXE;
      FL_BERR: return POS_BERR;
      FL_ARLO: return POS_ARLO;
      default: return POS_AF;
    endcase
  endfunction

  function automatic bit isErrFlag(input int idx);
    return (idx == FL_BERR) || (idx == FL_ARLO) || (idx == FL_AF);
  endfunction

  function automatic bit isSeqFlag(input int idx);
    return (idx == FL_SB) || (idx == FL_ADDR) || (idx == FL_BTF);
  endfunction

endpackage

// File: rtl/i2cirq_ctrl.sv
module i2cirq_ctrl
  import i2cirq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              dataWrStb,
  input  logic              dataRdStb,
  output strobe_t           stb,
  output rdSel_e            rdSel
);

  localparam logic [ADDR_W-1:0] A_CR2 = ADDR_W'(OFS_CR2);
  localparam logic [ADDR_W-1:0] A_SR1 = ADDR_W'(OFS_SR1);
  localparam logic [ADDR_W-1:0] A_SR2 = ADDR_W'(OFS_SR2);

  logic hitCr2, hitSr1, hitSr2;

  assign hitCr2 = (regAddr == A_CR2);
  assign hitSr1 = (regAddr == A_SR1);
  assign hitSr2 = (regAddr == A_SR2);

  always_comb begin
    stb        = '0;
    stb.cr2Wr  = regWr & hitCr2;
    stb.sr1Wr  = regWr & hitSr1;
    stb.sr1Rd  = regRd & hitSr1;
    stb.sr2Rd  = regRd & hitSr2;
    stb.dataWr = dataWrStb;
    stb.dataRd = dataRdStb;
  end

  always_comb begin
    if (hitCr2)      rdSel = RS_CR2;
    else if (hitSr1) rdSel = RS_SR1;
    else if (hitSr2) rdSel = RS_SR2;
    else             rdSel = RS_NONE;
  end

endmodule

// File: rtl/i2cirq_flags.sv
module i2cirq_flags
  import i2cirq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  rdSel_e               rdSel,
  input  logic [REG_W-1:0]     wrData,
  input  logic [NUM_FLAGS-1:0] setPulse,
  output logic [REG_W-1:0]     cr2Q,
  output logic [REG_W-1:0]     sr1Vec,
  output logic [REG_W-1:0]     rdData,
  output logic                 evtIrq,
  output logic                 errIrq
);

  localparam logic [REG_W-1:0] CR2_MASK =
      REG_W'((1 << FREQ_W) - 1) |
      (REG_W'(1) << ERREN_BIT) |
      (REG_W'(1) << EVTEN_BIT) |
      (REG_W'(1) << BUFEN_BIT);

  logic [NUM_FLAGS-1:0] flagQ, flagD;
  logic [NUM_FLAGS-1:0] armQ, armD;
  logic [NUM_FLAGS-1:0] clrHit;

  // per-flag clear source, next state and read-sequence arming
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam int POS = statusPos(i);

    if (isErrFlag(i)) begin : g_err
      assign clrHit[i] = stb.sr1Wr & ~wrData[POS];
    end else if (i == FL_SB) begin : g_sb
      assign clrHit[i] = stb.dataWr & armQ[i];
    end else if (i == FL_ADDR) begin : g_addr
      assign clrHit[i] = stb.sr2Rd & armQ[i];
    end else if (i == FL_BTF) begin : g_btf
      assign clrHit[i] = (stb.dataWr | stb.dataRd) & armQ[i];
    end else if (i == FL_RXNE) begin : g_rxne
      assign clrHit[i] = stb.dataRd;
    end else begin : g_txe
      assign clrHit[i] = stb.dataWr;
    end

    // a new event outranks any clear in the same cycle
    assign flagD[i] = setPulse[i] | (flagQ[i] & ~clrHit[i]);

    if (isSeqFlag(i)) begin : g_arm
      assign armD[i] = flagD[i] & ~clrHit[i] & (armQ[i] | (stb.sr1Rd & flagQ[i]));
    end else begin : g_noarm
      assign armD[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      armQ  <= '0;
      cr2Q  <= '0;
    end else begin
      flagQ <= flagD;
      armQ  <= armD;
      if (stb.cr2Wr) cr2Q <= wrData & CR2_MASK;
    end
  end

  always_comb begin
    sr1Vec = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      sr1Vec[statusPos(i)] = flagQ[i];
    end
  end

  logic evtEn, errEn, bufEn;
  logic evtCore, bufAny, errAny;

  assign evtEn   = cr2Q[EVTEN_BIT];
  assign errEn   = cr2Q[ERREN_BIT];
  assign bufEn   = cr2Q[BUFEN_BIT];
  assign evtCore = flagQ[FL_SB] | flagQ[FL_ADDR] | flagQ[FL_BTF];
  assign bufAny  = flagQ[FL_TXE] | flagQ[FL_RXNE];
  assign errAny  = flagQ[FL_BERR] | flagQ[FL_ARLO] | flagQ[FL_AF];

  assign evtIrq = evtEn & (evtCore | (bufEn & bufAny));
  assign errIrq = errEn & errAny;

  always_comb begin
    case (rdSel)
      RS_CR2:  rdData = cr2Q;
      RS_SR1:  rdData = sr1Vec;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/i2cirq_top.sv
module i2cirq_top
  import i2cirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 dataWrStb,
  input  logic                 dataRdStb,
  input  logic [NUM_FLAGS-1:0] setPulse,
  output logic [REG_W-1:0]     statusOut,
  output logic                 evtIrq,
  output logic                 errIrq
);

  strobe_t          stb;
  rdSel_e           rdSel;
  logic [REG_W-1:0] cr2Q;

  i2cirq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .dataWrStb (dataWrStb),
    .dataRdStb (dataRdStb),
    .stb       (stb),
    .rdSel     (rdSel)
  );

  i2cirq_flags #(.REG_W(REG_W)) u_flags (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .wrData   (regWrData),
    .setPulse (setPulse),
    .cr2Q     (cr2Q),
    .sr1Vec   (statusOut),
    .rdData   (regRdData),
    .evtIrq   (evtIrq),
    .errIrq   (errIrq)
  );

endmodule

// File: rtl/i2cirq_chk.sv
module i2cirq_chk
  import i2cirq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWr,
  input logic                 regRd,
  input logic [2:0]           errKeepWr,
  input logic                 dataWrStb,
  input logic                 dataRdStb,
  input logic [NUM_FLAGS-1:0] setPulse,
  input logic [NUM_FLAGS-1:0] stat,
  input logic                 evtIrq,
  input logic                 errIrq,
  input logic                 errEn,
  input logic                 evtEn,
  input logic                 bufEn
);

  logic sr1WrHit, sr2RdHit;
  assign sr1WrHit = regWr && (regAddr == ADDR_W'(OFS_SR1));
  assign sr2RdHit = regRd && (regAddr == ADDR_W'(OFS_SR2));

  a_r3_sb_visible: assert property (@(posedge clk) disable iff (!rstN)
    setPulse[FL_SB] |=> stat[FL_SB]);

  a_r3_af_visible: assert property (@(posedge clk) disable iff (!rstN)
    setPulse[FL_AF] |=> stat[FL_AF]);

  a_r4_evt_level: assert property (@(posedge clk) disable iff (!rstN)
    (evtEn && stat[FL_ADDR]) |-> evtIrq);

  a_r5_buf_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!bufEn && !stat[FL_SB] && !stat[FL_ADDR] && !stat[FL_BTF]) |-> !evtIrq);

  a_r6_err_src: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> (errEn && (stat[FL_BERR] || stat[FL_ARLO] || stat[FL_AF])));

  a_r7_keep_ones: assert property (@(posedge clk) disable iff (!rstN)
    (sr1WrHit && errKeepWr == 3'b111 && !dataRdStb)
      |=> (($past(stat[FL_AF:FL_BERR]) & ~stat[FL_AF:FL_BERR]) == 3'b000));

  a_r8_sb_by_dwr: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stat[FL_SB]) |-> $past(dataWrStb));

  a_r9_addr_by_sr2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stat[FL_ADDR]) |-> $past(sr2RdHit));

  a_r11_rxne_clear: assert property (@(posedge clk) disable iff (!rstN)
    (dataRdStb && !setPulse[FL_RXNE]) |=> !stat[FL_RXNE]);

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (setPulse[FL_TXE] && dataWrStb) |=> stat[FL_TXE]);

endmodule

bind i2cirq_top i2cirq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWr     (regWr),
  .regRd     (regRd),
  .errKeepWr (regWrData[i2cirq_pkg::POS_AF:i2cirq_pkg::POS_BERR]),
  .dataWrStb (dataWrStb),
  .dataRdStb (dataRdStb),
  .setPulse  (setPulse),
  .stat      ({statusOut[i2cirq_pkg::POS_AF:i2cirq_pkg::POS_RXNE],
               statusOut[i2cirq_pkg::POS_BTF:i2cirq_pkg::POS_SB]}),
  .evtIrq    (evtIrq),
  .errIrq    (errIrq),
  .errEn     (cr2Q[i2cirq_pkg::ERREN_BIT]),
  .evtEn     (cr2Q[i2cirq_pkg::EVTEN_BIT]),
  .bufEn     (cr2Q[i2cirq_pkg::BUFEN_BIT])
);

// File: tb/sim_i2cirq_top.sv
module sim_i2cirq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        dataWrStb = 1'b0;
  logic        dataRdStb = 1'b0;
  logic [7:0]  setPulse = '0;
  logic [15:0] statusOut;
  logic        evtIrq;
  logic        errIrq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // set-pulse masks (index order of R3)
  localparam logic [7:0] P_SB = 8'h01, P_ADDR = 8'h02, P_BTF = 8'h04, P_RXNE = 8'h08,
                         P_TXE = 8'h10, P_BERR = 8'h20, P_ARLO = 8'h40, P_AF = 8'h80;
  localparam logic [7:0] A_CR2 = 8'h04, A_SR1 = 8'h14, A_SR2 = 8'h18;

  always #2 clk = ~clk;

  i2cirq_top u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .dataWrStb(dataWrStb),
    .dataRdStb(dataRdStb), .setPulse(setPulse), .statusOut(statusOut),
    .evtIrq(evtIrq), .errIrq(errIrq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one bus cycle; on return the clock edge has taken effect
  task automatic cyc(input logic [7:0] sp, input logic w, input logic r, input logic [7:0] a,
                     input logic [15:0] d, input logic dw, input logic dr, output logic [15:0] rd);
    @(negedge clk);
    setPulse = sp; regWr = w; regRd = r; regAddr = a; regWrData = d;
    dataWrStb = dw; dataRdStb = dr;
    #1 rd = regRdData;
    @(negedge clk);
    setPulse = '0; regWr = 1'b0; regRd = 1'b0; regAddr = '0; regWrData = '0;
    dataWrStb = 1'b0; dataRdStb = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] sp);
    logic [15:0] rd;
    cyc(sp, 1'b0, 1'b0, 8'h00, 16'h0, 1'b0, 1'b0, rd);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] rd;
    cyc(8'h00, 1'b1, 1'b0, a, d, 1'b0, 1'b0, rd);
  endtask

  task automatic regRead(input logic [7:0] a, output logic [15:0] rd);
    cyc(8'h00, 1'b0, 1'b1, a, 16'h0, 1'b0, 1'b0, rd);
  endtask

  task automatic dataWrite();
    logic [15:0] rd;
    cyc(8'h00, 1'b0, 1'b0, 8'h00, 16'h0, 1'b1, 1'b0, rd);
  endtask

  task automatic dataRead();
    logic [15:0] rd;
    cyc(8'h00, 1'b0, 1'b0, 8'h00, 16'h0, 1'b0, 1'b1, rd);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] rd;
    doReset();
    check(statusOut == 16'h0, "R1 status after reset", statusOut, 16'h0);
    check(!evtIrq && !errIrq, "R1 irqs after reset", {evtIrq, errIrq}, 0);
    regRead(A_CR2, rd);
    check(rd == 16'h0, "R1 control after reset", rd, 16'h0);
  endtask

  task automatic t_ctrlReg();
    logic [15:0] rd;
    doReset();
    regWrite(A_CR2, 16'hFFFF);
    regRead(A_CR2, rd);
    check(rd == 16'h073F, "R2 control mask", rd, 16'h073F);
    regWrite(A_CR2, 16'h0215);
    regRead(A_CR2, rd);
    check(rd == 16'h0215, "R2 control value", rd, 16'h0215);
    pulse(8'hFF);
    regRead(A_SR2, rd);
    check(rd == 16'h0, "R2 status2 reads zero", rd, 16'h0);
    regRead(8'h30, rd);
    check(rd == 16'h0, "R2 unmapped reads zero", rd, 16'h0);
  endtask

  task automatic t_setAll();
    logic [15:0] rd;
    doReset();
    pulse(8'hFF);
    check(statusOut == 16'h07C7, "R3 all flags positions", statusOut, 16'h07C7);
    regRead(A_SR1, rd);
    check(rd == 16'h07C7, "R3 status1 readback", rd, 16'h07C7);
    doReset();
    pulse(P_RXNE);
    check(statusOut == 16'h0040, "R3 receive full at bit 6", statusOut, 16'h0040);
  endtask

  task automatic t_evtIrq();
    doReset();
    pulse(P_ADDR);
    check(!evtIrq, "R4 no irq while disabled", evtIrq, 0);
    regWrite(A_CR2, 16'h0200);
    check(evtIrq, "R4 irq on address flag", evtIrq, 1);
    doReset();
    regWrite(A_CR2, 16'h0200);
    pulse(P_BTF);
    check(evtIrq, "R4 irq on byte finished", evtIrq, 1);
  endtask

  task automatic t_bufGate();
    doReset();
    regWrite(A_CR2, 16'h0200);
    pulse(P_TXE);
    check(!evtIrq, "R5 transmit empty without buffer enable", evtIrq, 0);
    regWrite(A_CR2, 16'h0600);
    check(evtIrq, "R5 transmit empty with both enables", evtIrq, 1);
    regWrite(A_CR2, 16'h0400);
    check(!evtIrq, "R5 buffer enable alone", evtIrq, 0);
  endtask

  task automatic t_errIrq();
    doReset();
    regWrite(A_CR2, 16'h0100);
    check(!errIrq, "R6 no irq without flag", errIrq, 0);
    pulse(P_ARLO);
    check(errIrq, "R6 irq on arbitration lost", errIrq, 1);
    check(!evtIrq, "R6 error flag not on event line", evtIrq, 0);
    regWrite(A_CR2, 16'h0000);
    check(!errIrq, "R6 irq gated by enable", errIrq, 0);
  endtask

  task automatic t_errClear();
    doReset();
    pulse(P_AF | P_ARLO | P_BERR | P_SB);
    check(statusOut == 16'h0701, "R7 setup", statusOut, 16'h0701);
    regWrite(A_SR1, 16'hFDFF);
    check(statusOut == 16'h0501, "R7 zero clears only bit 9", statusOut, 16'h0501);
    regWrite(A_SR1, 16'h0000);
    check(statusOut == 16'h0001, "R7 start flag untouched by write", statusOut, 16'h0001);
  endtask

  task automatic t_startSeq();
    logic [15:0] rd;
    doReset();
    pulse(P_SB);
    dataWrite();
    check(statusOut[0], "R8 write without status read keeps start", statusOut[0], 1);
    regRead(A_SR1, rd);
    check(statusOut[0], "R8 status read alone keeps start", statusOut[0], 1);
    dataWrite();
    check(!statusOut[0], "R8 read then write clears start", statusOut[0], 0);
  endtask

  task automatic t_addrSeq();
    logic [15:0] rd;
    doReset();
    pulse(P_ADDR);
    regRead(A_SR2, rd);
    check(statusOut[1], "R9 status2 read alone keeps address", statusOut[1], 1);
    regRead(A_SR1, rd);
    dataWrite();
    check(statusOut[1], "R9 data write does not clear address", statusOut[1], 1);
    regRead(A_SR2, rd);
    check(!statusOut[1], "R9 sequence clears address", statusOut[1], 0);
  endtask

  task automatic t_btfSeq();
    logic [15:0] rd;
    doReset();
    pulse(P_BTF);
    dataRead();
    check(statusOut[2], "R10 data read alone keeps byte finished", statusOut[2], 1);
    regRead(A_SR1, rd);
    dataRead();
    check(!statusOut[2], "R10 read sequence clears byte finished", statusOut[2], 0);
    pulse(P_BTF);
    regRead(A_SR1, rd);
    dataWrite();
    check(!statusOut[2], "R10 write sequence clears byte finished", statusOut[2], 0);
  endtask

  task automatic t_bufClear();
    doReset();
    pulse(P_TXE | P_RXNE);
    dataWrite();
    check(statusOut[7:6] == 2'b01, "R11 write clears transmit empty only", statusOut[7:6], 2'b01);
    dataRead();
    check(statusOut[7:6] == 2'b00, "R11 read clears receive full", statusOut[7:6], 2'b00);
  endtask

  task automatic t_coincide();
    logic [15:0] rd;
    doReset();
    pulse(P_TXE);
    cyc(P_TXE, 1'b0, 1'b0, 8'h00, 16'h0, 1'b1, 1'b0, rd);
    check(statusOut[7], "R12 set wins over data write", statusOut[7], 1);
    pulse(P_AF);
    cyc(P_AF, 1'b1, 1'b0, A_SR1, 16'h0000, 1'b0, 1'b0, rd);
    check(statusOut[10], "R12 set wins over zero write", statusOut[10], 1);
    pulse(P_SB);
    regRead(A_SR1, rd);
    cyc(P_SB, 1'b0, 1'b0, 8'h00, 16'h0, 1'b1, 1'b0, rd);
    check(statusOut[0], "R12 set wins over start clear", statusOut[0], 1);
    dataWrite();
    check(statusOut[0], "R12 earlier status read cancelled", statusOut[0], 1);
    regRead(A_SR1, rd);
    dataWrite();
    check(!statusOut[0], "R12 fresh read then write clears", statusOut[0], 0);
  endtask

  initial begin
    t_reset();
    t_ctrlReg();
    t_setAll();
    t_evtIrq();
    t_bufGate();
    t_errIrq();
    t_errClear();
    t_startSeq();
    t_addrSeq();
    t_btfSeq();
    t_bufClear();
    t_coincide();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule